// File: doc/BRIEF.md
# Indexed Register and Memory Access Window

This block is a two-register indirect access port at the front of a 16 KiB register space. A host sees a 32-bit little-endian bus. Each access carries a byte address and a size of 1, 2 or 4 bytes, and its data is right-aligned. A pointer register (the index) sits at byte addresses 0x000 to 0x003. The four byte addresses 0x004 to 0x007 form the data window. An access to the window goes to one of two places, chosen by index bit 31: video memory, at the byte address held in the index, or back into the register space, at the index plus the window byte offset.

Accesses to addresses outside the window go straight to an external register file through a word-wide request port with byte enables. The block does all byte-lane work itself: extraction on reads, lane-selective merging on writes, the size-aware bounds check on memory, and splitting a memory access that crosses a 32-bit word into two word beats on a valid/ready memory port. Guards keep a forwarded access from re-entering the window and keep writes away from the read-only mirror at 0xF00 to 0xFFF.

Top module: `idxwin_top`

## Requirements
- R1: After synchronous active-low reset, req_ready is 1, rsp_valid, rf_valid and mem_valid are 0, and the index reads as 0.
- R2: Sizes are encoded 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. An access to address 0x000 to 0x003 acts on the 32-bit index at byte offset addr[1:0]. A read returns the selected bytes right-aligned. A write replaces only those byte lanes.
- R3: All four addresses 0x004 to 0x007 are routed through the window.
- R4: With index bit 31 set, a window access targets memory at byte address index[30:0], ignoring the window offset. The lowest memory address maps to data bits 7:0 (little-endian).
- R5: A memory access is performed only if index[30:0] + size <= MEM_BYTES. Otherwise a read returns 0, a write produces no memory transaction, and the response still arrives one cycle later.
- R6: A memory access whose bytes cross a 32-bit word boundary is carried as two beats, word w first and then w+1, each with its own byte enables. Otherwise exactly one beat is used.
- R7: With index bit 31 clear, a window access is forwarded to register byte address index + (addr - 0x004), with the same size.
- R8: Register-file accesses use word address tgt[13:2] and byte enables equal to the size lanes shifted by tgt[1:0]. Lanes beyond byte 3 are dropped, and reads return the same lanes right-aligned.
- R9: Writes whose target lies in 0xF00 to 0xFFF, direct or forwarded, raise no register-file write, so later reads there are unchanged.
- R10: A forwarded target that lands in the window (0x004 to 0x007) or at or above 0x4000 is blocked: a read returns 0 and nothing is written. A forwarded target in 0x000 to 0x003 acts on the index itself.
- R11: Direct accesses to any other address go to the register file, whose read data is taken in the request cycle.
- R12: Responses that need no memory transaction arrive exactly one cycle after acceptance. Memory responses arrive one cycle after the last beat completes, with req_ready low until then. Write responses carry 0.
- R13: While mem_valid is high and mem_ready is low, mem_valid and all request fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Host byte address |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Right-aligned write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Right-aligned read data, 0 for writes |
| rf_valid | output | 1 | Register-file request, single cycle |
| rf_write | output | 1 | Register-file write |
| rf_addr | output | 12 | Register-file word address |
| rf_be | output | 4 | Register-file byte enables |
| rf_wdata | output | 32 | Lane-aligned write data |
| rf_rdata | input | 32 | Register-file word read back in the same cycle |
| mem_valid | output | 1 | Memory beat request |
| mem_ready | input | 1 | Memory accepts the beat |
| mem_write | output | 1 | Memory write beat |
| mem_addr | output | MEM_AW | Memory word address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Lane-aligned memory write data |
| mem_rvalid | input | 1 | Memory read data valid |
| mem_rdata | input | 32 | Memory read word |

## Verification
Index, register-file and blocked accesses answer exactly one cycle after the accepting edge. The bench samples rsp_valid at the falling edge that follows that edge and counts a missing strobe there as a failure. Memory accesses have no fixed latency, because the bench's memory stalls mem_ready in a repeating pattern and returns read words two cycles after a beat. For these the bench polls once per falling edge, checks that req_ready stays low until the response, and compares the beat handshake count with the one or two beats its own model predicts. Every read value is compared with a behavioural reference model that updates the index, the register words and a byte-wise memory as each access is issued.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

    localparam int unsigned REG_AW    = 14;
    localparam int unsigned WORD_AW   = REG_AW - 2;
    localparam int unsigned REG_BYTES = 1 << REG_AW;

    localparam logic [WORD_AW-1:0] INDEX_WORD = WORD_AW'(0);
    localparam logic [WORD_AW-1:0] DATA_WORD  = WORD_AW'(1);
    localparam logic [WORD_AW-1:0] MIRROR_LO  = WORD_AW'(12'h3C0);
    localparam logic [WORD_AW-1:0] MIRROR_HI  = WORD_AW'(12'h3FF);

    typedef enum logic [1:0] {RT_INDEX, RT_RF, RT_MEM, RT_NONE} route_e;
    typedef enum logic [1:0] {MS_IDLE, MS_CMD, MS_WAIT} mseq_e;

    // byte count of a size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // byte-lane mask of a size code, right-aligned
    function automatic logic [3:0] lane_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 4'b0001;
            2'd1:    return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    // bit mask of a size code, right-aligned
    function automatic logic [31:0] size_mask(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // classify a register word that is not the window itself
    function automatic route_e reg_route(input logic [WORD_AW-1:0] w, input logic wr);
        if (w == INDEX_WORD) return RT_INDEX;
        if (wr && (w >= MIRROR_LO) && (w <= MIRROR_HI)) return RT_NONE;
        return RT_RF;
    endfunction

endpackage

// File: rtl/idxwin_route.sv
// Access decoder.
// Decides where a host access goes (index, register file, memory or
// nowhere) and computes the register target byte address. Purely
// combinational. Assumes MEM_BYTES < 2^31.
module idxwin_route
    import idxwin_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0100_0000
) (
    input  logic [REG_AW-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [31:0]       index_q,
    output route_e            route,
    output logic [REG_AW-1:0] tgt
);
    logic [32:0] fwd_sum;
    logic [32:0] mem_end;
    logic        mem_ok;

    // decode target and route of the presented access
    always_comb begin
        fwd_sum = {1'b0, index_q} + 33'(req_addr[1:0]);
        mem_end = {2'b00, index_q[30:0]} + 33'(size_bytes(req_size));
        mem_ok  = (mem_end <= 33'(MEM_BYTES));
        tgt     = req_addr;
        route   = RT_NONE;
        if (req_addr[REG_AW-1:2] != DATA_WORD) begin
            route = reg_route(req_addr[REG_AW-1:2], req_write);
        end else if (index_q[31]) begin
            route = mem_ok ? RT_MEM : RT_NONE;
        end else if (fwd_sum < 33'(REG_BYTES)) begin
            tgt = fwd_sum[REG_AW-1:0];
            if (tgt[REG_AW-1:2] != DATA_WORD)
                route = reg_route(tgt[REG_AW-1:2], req_write);
        end
    end
endmodule

// File: rtl/idxwin_lanes.sv
// Byte-lane unit for one 32-bit register word.
// Extracts a right-aligned field at a byte offset, forms byte enables
// and lane-aligned write data, and merges the write into the word.
// Lanes past byte 3 fall off. Purely combinational.
module idxwin_lanes (
    input  logic [31:0] word_in,
    input  logic [1:0]  off,
    input  logic [1:0]  size,
    input  logic [31:0] wdata,
    output logic [31:0] extract,
    output logic [3:0]  be,
    output logic [31:0] lanes,
    output logic [31:0] merged
);
    import idxwin_pkg::*;

    logic [4:0] shamt;

    // shift amounts, enables and aligned data
    always_comb begin
        shamt   = {off, 3'b000};
        extract = (word_in >> shamt) & size_mask(size);
        be      = lane_mask(size) << off;
        lanes   = wdata << shamt;
    end

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign merged[8*g +: 8] = be[g] ? lanes[8*g +: 8] : word_in[8*g +: 8];
    end
endmodule

// File: rtl/idxwin_mem_seq.sv
// Memory beat sequencer.
// Runs one memory access of 1, 2 or 4 bytes at any byte address. It
// splits the access into one or two word beats, holds each beat until
// mem_ready, waits for read data, and assembles the little-endian
// result. It raises fin in the cycle the last beat completes. Assumes
// the caller has already bounds-checked the address and that memory
// returns one read word per read beat.
module idxwin_mem_seq
    import idxwin_pkg::*;
#(
    parameter int unsigned MBW = 24,
    localparam int unsigned MAW = MBW - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           wr,
    input  logic [MBW-1:0] idx,
    input  logic [1:0]     size,
    input  logic [31:0]    wdata,
    output logic           idle,
    output logic           fin,
    output logic [31:0]    fin_rdata,
    output logic           mem_valid,
    input  logic           mem_ready,
    output logic           mem_write,
    output logic [MAW-1:0] mem_addr,
    output logic [3:0]     mem_be,
    output logic [31:0]    mem_wdata,
    input  logic           mem_rvalid,
    input  logic [31:0]    mem_rdata
);
    mseq_e          state_q;
    logic           wr_q, beat_q, two_q;
    logic [7:0]     be8_q;
    logic [63:0]    d64_q;
    logic [MAW-1:0] wa_q;
    logic [1:0]     off_q, size_q;
    logic [31:0]    hold_q;
    logic [7:0]     be8_n;
    logic [63:0]    full64;
    logic           last_beat;

    // spread the request over eight byte lanes
    assign be8_n = {4'b0000, lane_mask(size)} << idx[1:0];

    // drive the current beat
    always_comb begin
        idle      = (state_q == MS_IDLE);
        mem_valid = (state_q == MS_CMD);
        mem_write = wr_q;
        mem_addr  = beat_q ? wa_q + MAW'(1) : wa_q;
        mem_be    = beat_q ? be8_q[7:4] : be8_q[3:0];
        mem_wdata = beat_q ? d64_q[63:32] : d64_q[31:0];
    end

    // completion detection and little-endian result assembly
    always_comb begin
        last_beat = beat_q || !two_q;
        fin = ((state_q == MS_CMD) && mem_ready && wr_q && last_beat) ||
              ((state_q == MS_WAIT) && mem_rvalid && last_beat);
        full64 = beat_q ? {mem_rdata, hold_q} : {32'h0, mem_rdata};
        fin_rdata = wr_q ? 32'h0 : (full64[{off_q, 3'b000} +: 32] & size_mask(size_q));
    end

    // sequencer state and captured access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MS_IDLE;
            beat_q  <= 1'b0;
            two_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            case (state_q)
                MS_IDLE: if (start) begin
                    wr_q    <= wr;
                    beat_q  <= 1'b0;
                    be8_q   <= be8_n;
                    two_q   <= |be8_n[7:4];
                    d64_q   <= {32'h0, wdata} << {idx[1:0], 3'b000};
                    wa_q    <= idx[MBW-1:2];
                    off_q   <= idx[1:0];
                    size_q  <= size;
                    state_q <= MS_CMD;
                end
                MS_CMD: if (mem_ready) begin
                    if (!wr_q)         state_q <= MS_WAIT;
                    else if (last_beat) state_q <= MS_IDLE;
                    else               beat_q  <= 1'b1;
                end
                MS_WAIT: if (mem_rvalid) begin
                    if (last_beat) begin
                        state_q <= MS_IDLE;
                    end else begin
                        hold_q  <= mem_rdata;
                        beat_q  <= 1'b1;
                        state_q <= MS_CMD;
                    end
                end
                default: state_q <= MS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/idxwin_top.sv
// Indexed access window top.
// Holds the index register, routes each host access, performs register
// accesses in the cycle of acceptance and hands memory accesses to the
// beat sequencer. The host sees one response per access. Assumes the
// register file answers reads combinationally and that MEM_BYTES is a
// power of two no larger than 2^30.
module idxwin_top
    import idxwin_pkg::*;
#(
    parameter int unsigned MEM_BYTES = 32'h0100_0000,
    localparam int unsigned MBW    = $clog2(MEM_BYTES),
    localparam int unsigned MEM_AW = MBW - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [REG_AW-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rf_valid,
    output logic              rf_write,
    output logic [WORD_AW-1:0] rf_addr,
    output logic [3:0]        rf_be,
    output logic [31:0]       rf_wdata,
    input  logic [31:0]       rf_rdata,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_write,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    input  logic              mem_rvalid,
    input  logic [31:0]       mem_rdata
);
    logic [31:0]       index_q;
    route_e            route;
    logic [REG_AW-1:0] tgt;
    logic              accept, seq_idle, fin;
    logic [31:0]       fin_rdata, word_in, extract, lanes, merged;
    logic [3:0]        be;
    logic              rsp_valid_q;
    logic [31:0]       rsp_rdata_q;

    idxwin_route #(.MEM_BYTES(MEM_BYTES)) u_route (
        .req_addr (req_addr),
        .req_size (req_size),
        .req_write(req_write),
        .index_q  (index_q),
        .route    (route),
        .tgt      (tgt)
    );

    // the lane unit sees the index or the register-file word
    assign word_in = (route == RT_INDEX) ? index_q : rf_rdata;

    idxwin_lanes u_lanes (
        .word_in(word_in),
        .off    (tgt[1:0]),
        .size   (req_size),
        .wdata  (req_wdata),
        .extract(extract),
        .be     (be),
        .lanes  (lanes),
        .merged (merged)
    );

    idxwin_mem_seq #(.MBW(MBW)) u_mseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept && (route == RT_MEM)),
        .wr        (req_write),
        .idx       (index_q[MBW-1:0]),
        .size      (req_size),
        .wdata     (req_wdata),
        .idle      (seq_idle),
        .fin       (fin),
        .fin_rdata (fin_rdata),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_write (mem_write),
        .mem_addr  (mem_addr),
        .mem_be    (mem_be),
        .mem_wdata (mem_wdata),
        .mem_rvalid(mem_rvalid),
        .mem_rdata (mem_rdata)
    );

    // host handshake and register-file request
    always_comb begin
        req_ready = seq_idle;
        accept    = req_valid && req_ready;
        rf_valid  = accept && (route == RT_RF);
        rf_write  = req_write;
        rf_addr   = tgt[REG_AW-1:2];
        rf_be     = be;
        rf_wdata  = lanes;
    end

    // index register with byte-lane merge
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= 32'h0;
        else if (accept && req_write && (route == RT_INDEX))
            index_q <= merged;
    end

    // one registered response per access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= 32'h0;
        end else begin
            rsp_valid_q <= (accept && (route != RT_MEM)) || fin;
            if (fin)
                rsp_rdata_q <= fin_rdata;
            else if (accept && !req_write && ((route == RT_INDEX) || (route == RT_RF)))
                rsp_rdata_q <= extract;
            else
                rsp_rdata_q <= 32'h0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;
endmodule

// File: rtl/idxwin_chk.sv
// Protocol checker for the indexed access window, attached by bind.
module idxwin_chk
    import idxwin_pkg::*;
#(
    parameter int unsigned MAW = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [REG_AW-1:0]  req_addr,
    input logic               rsp_valid,
    input logic [31:0]        index_q,
    input logic               rf_valid,
    input logic               rf_write,
    input logic [WORD_AW-1:0] rf_addr,
    input logic [3:0]         rf_be,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic               mem_write,
    input logic [MAW-1:0]     mem_addr,
    input logic [3:0]         mem_be,
    input logic [31:0]        mem_wdata
);
    // R13
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                       && $stable(mem_write) && $stable(mem_wdata)));

    // R12
    mem_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !req_ready);

    // R12
    rsp_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !((req_addr[REG_AW-1:2] == DATA_WORD) && index_q[31]))
        |=> rsp_valid);

    // R9
    mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_valid && rf_write) |-> !((rf_addr >= MIRROR_LO) && (rf_addr <= MIRROR_HI)));

    // R10
    no_recur_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |-> ((rf_addr != DATA_WORD) && (rf_addr != INDEX_WORD)));

    // R8
    rf_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_valid |-> (rf_be != 4'b0000));
endmodule

bind idxwin_top idxwin_chk #(.MAW(MEM_AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .index_q  (index_q),
    .rf_valid (rf_valid),
    .rf_write (rf_write),
    .rf_addr  (rf_addr),
    .rf_be    (rf_be),
    .mem_valid(mem_valid),
    .mem_ready(mem_ready),
    .mem_write(mem_write),
    .mem_addr (mem_addr),
    .mem_be   (mem_be),
    .mem_wdata(mem_wdata)
);

// File: tb/sim_idxwin_top.sv
module sim_idxwin_top;
    localparam int unsigned MEMB = 32'h0100_0000;
    localparam int MAW = 22;

    bit clk = 1'b0;
    bit rst_n = 1'b0;
    bit req_valid = 1'b0, req_write = 1'b0;
    bit [13:0] req_addr = '0;
    bit [1:0]  req_size = '0;
    bit [31:0] req_wdata = '0;
    logic req_ready, rsp_valid;
    logic [31:0] rsp_rdata;
    logic rf_valid, rf_write;
    logic [11:0] rf_addr;
    logic [3:0] rf_be;
    logic [31:0] rf_wdata, rf_rdata;
    logic mem_valid, mem_write;
    bit mem_ready = 1'b0, mem_rvalid = 1'b0;
    bit [31:0] mem_rdata = '0;
    logic [MAW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata;

    always #4 clk = ~clk;

    idxwin_top #(.MEM_BYTES(MEMB)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rf_valid(rf_valid), .rf_write(rf_write), .rf_addr(rf_addr),
        .rf_be(rf_be), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    int nchk = 0, nerr = 0;
    int cyc = 0, mem_hs = 0, mirror_wr = 0;

    // environment: register file answering in the same cycle
    bit [31:0] env_rf [4096];
    assign rf_rdata = env_rf[rf_addr];

    // environment: byte memory with stalls and 2-cycle read latency
    bit [7:0] env_mem [int];
    bit rd1 = 1'b0;
    bit [MAW-1:0] rd1_addr = '0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= ((cyc % 3) != 1);
        if (rf_valid && rf_write) begin
            for (int k = 0; k < 4; k++)
                if (rf_be[k]) env_rf[rf_addr][8*k +: 8] <= rf_wdata[8*k +: 8];
            if (rf_addr >= 12'h3C0 && rf_addr <= 12'h3FF) mirror_wr <= mirror_wr + 1;
        end
        if (mem_valid && mem_ready) begin
            mem_hs <= mem_hs + 1;
            if (mem_write) begin
                for (int k = 0; k < 4; k++)
                    if (mem_be[k]) env_mem[int'({mem_addr, 2'b00}) + k] = mem_wdata[8*k +: 8];
            end
        end
        rd1 <= mem_valid && mem_ready && !mem_write;
        rd1_addr <= mem_addr;
        mem_rvalid <= rd1;
        if (rd1)
            for (int k = 0; k < 4; k++)
                mem_rdata[8*k +: 8] <= env_mem[int'({rd1_addr, 2'b00}) + k];
    end

    // R13 at the ports: a stalled beat keeps its fields
    bit p_stall = 1'b0;
    logic [MAW-1:0] p_addr;
    logic [3:0] p_be;
    logic [31:0] p_wd;
    logic p_wr;
    always @(negedge clk) begin
        if (rst_n && p_stall) begin
            nchk++;
            if (!(mem_valid && mem_addr == p_addr && mem_be == p_be && mem_wdata == p_wd && mem_write == p_wr)) begin
                nerr++;
                $display("FAIL R13 stalled beat changed: actual=%h/%h expected=%h/%h", mem_addr, mem_be, p_addr, p_be);
            end
        end
        p_stall = rst_n && mem_valid && !mem_ready;
        p_addr = mem_addr; p_be = mem_be; p_wd = mem_wdata; p_wr = mem_write;
    end

    // reference model state
    bit [31:0] r_index = '0;
    bit [31:0] r_rf [4096];
    bit [7:0]  r_mem [int];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit [31:0] ref_reg(input bit is_idx, input int t, input int n,
                                          input bit wr, input bit [31:0] wd);
        bit [31:0] w, res;
        int off;
        off = t & 3;
        w = is_idx ? r_index : r_rf[t >> 2];
        res = '0;
        for (int i = 0; i < n; i++) begin
            if (off + i < 4) begin
                if (wr) w[8*(off+i) +: 8] = wd[8*i +: 8];
                else    res[8*i +: 8] = w[8*(off+i) +: 8];
            end
        end
        if (wr) begin
            if (is_idx) r_index = w;
            else        r_rf[t >> 2] = w;
        end
        return res;
    endfunction

    function automatic bit [31:0] ref_target(input longint t, input int n, input bit wr, input bit [31:0] wd);
        if (t >= 64'h4000 || (t >> 2) == 1) return '0;
        if ((t >> 2) == 0) return ref_reg(1'b1, int'(t), n, wr, wd);
        if (wr && t >= 64'hF00 && t <= 64'hFFF) return '0;
        return ref_reg(1'b0, int'(t), n, wr, wd);
    endfunction

    task automatic ref_access(input bit wr, input int addr, input bit [1:0] sz, input bit [31:0] wd,
                              output bit [31:0] exp, output bit memp, output int beats);
        int n;
        longint a;
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        exp = '0; memp = 1'b0; beats = 0;
        if ((addr >> 2) != 1) begin
            exp = ref_target(longint'(addr), n, wr, wd);
        end else if (r_index[31]) begin
            a = longint'(r_index[30:0]);
            if (a + n <= longint'(MEMB)) begin
                memp = 1'b1;
                beats = (((a % 4) + n) > 4) ? 2 : 1;
                for (int i = 0; i < n; i++) begin
                    if (wr) r_mem[int'(a) + i] = wd[8*i +: 8];
                    else    exp[8*i +: 8] = r_mem[int'(a) + i];
                end
            end
        end else begin
            exp = ref_target(longint'(r_index) + longint'(addr - 4), n, wr, wd);
        end
        if (wr) exp = '0;
    endtask

    // one host access, checked against the reference model
    task automatic acc(input bit wr, input int addr, input bit [1:0] sz, input bit [31:0] wd, input string tag);
        bit [31:0] exp;
        bit memp;
        int beats, hs0, waitc;
        bit busy_ok;
        ref_access(wr, addr, sz, wd, exp, memp, beats);
        @(negedge clk);
        hs0 = mem_hs;
        req_valid = 1'b1; req_write = wr; req_addr = 14'(addr); req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (!memp) begin
            chk(rsp_valid === 1'b1, {tag, " R12 response one cycle after acceptance"}, 32'(rsp_valid), 32'd1);
        end else begin
            busy_ok = 1'b1;
            waitc = 0;
            while (rsp_valid !== 1'b1 && waitc < 200) begin
                if (req_ready !== 1'b0) busy_ok = 1'b0;
                @(negedge clk);
                waitc++;
            end
            chk(busy_ok && rsp_valid === 1'b1, {tag, " R12 busy until memory response"}, 32'(rsp_valid), 32'd1);
        end
        chk(rsp_rdata === exp, {tag, " data"}, rsp_rdata, exp);
        chk((mem_hs - hs0) == beats, {tag, " R6 memory beat count"}, 32'(mem_hs - hs0), 32'(beats));
    endtask

    initial begin
        #(8 * 100000);
        nerr++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && rf_valid === 1'b0 && mem_valid === 1'b0,
            "R1 idle outputs after reset", {req_ready, rsp_valid, rf_valid, mem_valid}, 32'h8);
        acc(0, 14'h000, 2, 0, "R1 index reads zero");

        // R2 index full and sub-word access
        acc(1, 14'h000, 2, 32'h1234_5678, "R2 index write");
        acc(0, 14'h000, 2, 0, "R2 index read");
        acc(1, 14'h002, 0, 32'h0000_00AB, "R2 byte merge");
        acc(0, 14'h000, 2, 0, "R2 merged word");
        acc(0, 14'h001, 1, 0, "R2 halfword extract");

        // R11 direct register accesses
        acc(1, 14'h100, 2, 32'hCAFE_F00D, "R11 direct write");
        acc(0, 14'h100, 2, 0, "R11 direct read");
        acc(0, 14'h103, 0, 0, "R11 byte read");
        acc(1, 14'h101, 1, 32'h0000_BEEF, "R8 halfword lanes");
        acc(0, 14'h100, 2, 0, "R8 merged register");

        // R7 forwarding through the window, R3 all window addresses
        acc(1, 14'h000, 2, 32'h0000_0100, "R7 set index");
        acc(0, 14'h004, 2, 0, "R7 forwarded word");
        acc(0, 14'h006, 1, 0, "R3 window offset 2");
        acc(1, 14'h005, 0, 32'h0000_0077, "R3 window offset 1 write");
        acc(0, 14'h100, 2, 0, "R7 forwarded write landed");
        acc(1, 14'h000, 2, 32'h0000_0102, "R8 set index");
        acc(1, 14'h005, 1, 32'h0000_5566, "R8 lane past word end");
        acc(0, 14'h100, 2, 0, "R8 only lane 3 written");
        acc(0, 14'h007, 2, 0, "R3 window offset 3");

        // R9 mirror writes ignored, reads still reach the file
        acc(1, 14'hF10, 2, 32'hDEAD_BEEF, "R9 direct mirror write");
        acc(0, 14'hF10, 2, 0, "R9 mirror unchanged");
        acc(1, 14'h000, 2, 32'h0000_0F20, "R9 set index");
        acc(1, 14'h004, 2, 32'h1111_2222, "R9 forwarded mirror write");
        acc(0, 14'h004, 2, 0, "R9 forwarded mirror read");
        chk(mirror_wr == 0, "R9 no mirror write strobes", 32'(mirror_wr), 32'd0);

        // R10 blocked targets and index re-entry
        acc(1, 14'h200, 2, 32'h0BAD_0BAD, "R10 preset");
        acc(1, 14'h000, 2, 32'h0000_0004, "R10 index to window");
        acc(0, 14'h004, 2, 0, "R10 window target reads zero");
        acc(1, 14'h004, 2, 32'h0000_0200, "R10 window target write dropped");
        acc(0, 14'h000, 2, 0, "R10 index unchanged");
        acc(1, 14'h000, 2, 32'h0000_3FFF, "R10 index near top");
        acc(0, 14'h005, 2, 0, "R10 out of space reads zero");
        acc(1, 14'h000, 2, 32'h0000_0000, "R10 index zero");
        acc(1, 14'h004, 2, 32'h0000_0200, "R10 window writes index");
        acc(0, 14'h004, 2, 0, "R10 forwarded read");

        // R4 memory, little-endian
        acc(1, 14'h000, 2, 32'h8000_0010, "R4 set index");
        acc(1, 14'h004, 2, 32'h1122_3344, "R4 memory write");
        acc(0, 14'h004, 2, 0, "R4 memory read");
        acc(0, 14'h007, 0, 0, "R4 offset ignored for memory");
        acc(1, 14'h000, 2, 32'h8000_0011, "R4 set index");
        acc(0, 14'h004, 0, 0, "R4 byte 1 lowest address");

        // R6 straddling accesses
        acc(1, 14'h000, 2, 32'h8000_0023, "R6 set index");
        acc(1, 14'h004, 2, 32'hA1B2_C3D4, "R6 straddle write");
        acc(0, 14'h004, 2, 0, "R6 straddle read");
        acc(1, 14'h000, 2, 32'h8000_0027, "R6 set index");
        acc(1, 14'h004, 1, 32'h0000_E5F6, "R6 halfword straddle");
        acc(0, 14'h004, 1, 0, "R6 halfword straddle read");

        // R5 bounds
        acc(1, 14'h000, 2, 32'h8000_0000 | (MEMB - 4), "R5 set index");
        acc(1, 14'h004, 2, 32'h7788_99AA, "R5 top word write");
        acc(0, 14'h004, 2, 0, "R5 top word read");
        acc(1, 14'h000, 2, 32'h8000_0000 | (MEMB - 3), "R5 set index");
        acc(1, 14'h004, 2, 32'hFFFF_FFFF, "R5 out of bounds write");
        acc(0, 14'h004, 2, 0, "R5 out of bounds read");
        acc(1, 14'h000, 2, 32'h8000_0000 | (MEMB - 2), "R5 set index");
        acc(0, 14'h004, 1, 0, "R5 halfword fits");
        acc(0, 14'h004, 2, 0, "R5 word exceeds");
        acc(0, 14'h004, 0, 0, "R5 byte fits");

        repeat (4) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule